// File: doc/BRIEF.md
# Dual-Issue Pairing Checker

This block sits between instruction decode and two in-order integer execution pipes, called U and V. Each cycle it receives two decoded instruction descriptors. Slot 0 holds the older instruction and slot 1 the younger one. The block decides whether both issue together as one group, or whether only the older one issues. In the second case the younger instruction is presented again in slot 0 on a later cycle.

Each descriptor carries the following fields:
- a base pairing class;
- a flag for extra opcode, operand-size or repeat prefixes;
- a flag marking an instruction that has both an immediate and a displacement;
- a stack-kind field;
- a long-operation kind.

From these fields the block derives an effective class for each slot. It then applies the slot restrictions and an externally computed register-hazard flag. A push or pop followed by another push, pop or call is exempt from that hazard. Long non-pairable operations hold both pipes for several cycles. A down-counter tracks this and is brought out as a stall count.

Top module: `dual_issue_pair`

## Requirements
- R1: An instruction whose `*_immdisp` flag is 1 is treated as not pairable, whatever its base class, so `issue_v` stays 0 whenever either slot sets it.
- R2: A prefixed instruction with base class either-pipe (code 00) is demoted to U-only (code 01). A prefix on any other class (01 U-only, 10 V-only, 11 not pairable) leaves the class unchanged.
- R3: With both slots valid and no stall, both issue (`issue_u`=1, `issue_v`=1) when the older effective class is 00 or 01 and the younger effective class is 00 or 10. In this case the hazard is clear or the stack exemption applies.
- R4: When the older effective class is V-only (10) or not pairable (11), only the older instruction issues.
- R5: When the younger effective class is U-only (01) or not pairable (11), only the older instruction issues.
- R6: `issue_v` is never 1 without `issue_u`. With slot 0 invalid nothing issues. With slot 1 invalid only U issues.
- R7: The long-operation kind is coded as 00 none, 01 direction-flag clear (2 cycles), 10 multiply (11 cycles) and 11 string (12 cycles). A long operation is not pairable. When it issues from slot 0, `stall_cnt` is loaded with its cycle count minus one on the next edge. The count then falls by one per cycle, and both issue outputs stay 0 while it is nonzero.
- R8: When `dep_hazard` is 1, pairing is refused unless the older stack kind is push/pop (01) and the younger stack kind is push/pop (01) or call (10).
- R9: Synchronous reset clears `stall_cnt` to 0, including in the middle of a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_valid | input | 1 | Older slot holds an instruction |
| a_cls | input | 2 | Older base class: 00 either pipe, 01 U only, 10 V only, 11 not pairable |
| a_prefix | input | 1 | Older instruction is prefixed |
| a_immdisp | input | 1 | Older instruction has immediate and displacement |
| a_stk | input | 2 | Older stack kind: 00 none, 01 push/pop, 10 call |
| a_long | input | 2 | Older long-operation kind |
| b_valid | input | 1 | Younger slot holds an instruction |
| b_cls | input | 2 | Younger base class, same coding |
| b_prefix | input | 1 | Younger instruction is prefixed |
| b_immdisp | input | 1 | Younger instruction has immediate and displacement |
| b_stk | input | 2 | Younger stack kind |
| b_long | input | 2 | Younger long-operation kind |
| dep_hazard | input | 1 | Younger reads a result of the older |
| issue_u | output | 1 | Older instruction issues into U |
| issue_v | output | 1 | Younger instruction issues into V |
| stall_cnt | output | CW | Remaining stall cycles of a long operation |

## Verification
The stall countdown and the pairing decision can fall in the same cycle. The bench provokes this by holding a fully pairable pair at the inputs for the whole length of a multiply, string or flag-clear stall. The model computes the exact cycle in which the count reaches zero, and both issue outputs must stay low until that cycle and go high in it. The hazard refusal and the push/pop exemption also meet in one decision. They are driven together with every stack-kind combination, and the model judges whether the pair goes out.

// File: rtl/pair_pkg.sv
package pair_pkg;

    typedef enum logic [1:0] {
        PC_UV = 2'b00,
        PC_PU = 2'b01,
        PC_PV = 2'b10,
        PC_NP = 2'b11
    } pair_cls_e;

    typedef enum logic [1:0] {
        LK_NONE = 2'b00,
        LK_CLD  = 2'b01,
        LK_MUL  = 2'b10,
        LK_STR  = 2'b11
    } long_kind_e;

    typedef enum logic [1:0] {
        SK_NONE    = 2'b00,
        SK_PUSHPOP = 2'b01,
        SK_CALL    = 2'b10,
        SK_RSVD    = 2'b11
    } stack_kind_e;

    typedef struct packed {
        logic        valid;
        pair_cls_e   cls;
        logic        prefix;
        logic        immdisp;
        stack_kind_e stk;
        long_kind_e  lng;
    } slot_desc_t;

    typedef struct packed {
        logic      valid;
        pair_cls_e eff;
        logic      stk_ok;
    } slot_info_t;

    function automatic pair_cls_e effective_class(slot_desc_t d);
        pair_cls_e c;
        if (d.immdisp || (d.lng != LK_NONE))
            c = PC_NP;
        else if ((d.cls == PC_UV) && d.prefix)
            c = PC_PU;
        else
            c = d.cls;
        return c;
    endfunction

    function automatic logic fits_u_slot(pair_cls_e c);
        return (c == PC_UV) || (c == PC_PU);
    endfunction

    function automatic logic fits_v_slot(pair_cls_e c);
        return (c == PC_UV) || (c == PC_PV);
    endfunction

endpackage

// File: rtl/pair_classify.sv
module pair_classify
    import pair_pkg::*;
#(
    parameter bit IS_OLDER = 1'b1
) (
    input  slot_desc_t desc,
    output slot_info_t info
);

    logic stk_flag;

    generate
        if (IS_OLDER) begin : g_older
            assign stk_flag = (desc.stk == SK_PUSHPOP);
        end else begin : g_younger
            assign stk_flag = (desc.stk == SK_PUSHPOP) || (desc.stk == SK_CALL);
        end
    endgenerate

    always_comb begin
        info.valid  = desc.valid;
        info.eff    = effective_class(desc);
        info.stk_ok = stk_flag;
    end

endmodule

// File: rtl/pair_decide.sv
module pair_decide
    import pair_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  slot_info_t older,
    input  slot_info_t younger,
    input  logic       hazard,
    input  logic       busy,
    output logic       issue_u,
    output logic       issue_v
);

    logic classes_ok;
    logic hazard_ok;

    always_comb begin
        classes_ok = fits_u_slot(older.eff) && fits_v_slot(younger.eff);
        hazard_ok  = !hazard || (older.stk_ok && younger.stk_ok);
        issue_u    = older.valid && !busy;
        issue_v    = issue_u && younger.valid && classes_ok && hazard_ok;
    end

    AST_V_NEEDS_U: assert property (@(posedge clk) disable iff (rst)
        issue_v |-> issue_u); // R6

    AST_NO_YOUNG_WITHOUT_OLD: assert property (@(posedge clk) disable iff (rst)
        !older.valid |-> !issue_u && !issue_v); // R6

endmodule

// File: rtl/pair_busy.sv
module pair_busy
    import pair_pkg::*;
#(
    parameter int CLD_CYC = 2,
    parameter int MUL_CYC = 11,
    parameter int STR_CYC = 12,
    parameter int CW      = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  long_kind_e    lng,
    output logic [CW-1:0] cnt,
    output logic          busy
);

    localparam logic [CW-1:0] CLD_M1 = CW'(CLD_CYC - 1);
    localparam logic [CW-1:0] MUL_M1 = CW'(MUL_CYC - 1);
    localparam logic [CW-1:0] STR_M1 = CW'(STR_CYC - 1);

    logic [CW-1:0] lat_m1;

    always_comb begin
        case (lng)
            LK_CLD:  lat_m1 = CLD_M1;
            LK_MUL:  lat_m1 = MUL_M1;
            LK_STR:  lat_m1 = STR_M1;
            default: lat_m1 = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
        else if (load)
            cnt <= lat_m1;
    end

    assign busy = (cnt != '0);

    AST_STALL_DECR: assert property (@(posedge clk) disable iff (rst)
        (cnt != '0) |=> (cnt == $past(cnt) - 1'b1)); // R7

    AST_MUL_LOAD: assert property (@(posedge clk) disable iff (rst)
        (load && !busy && lng == LK_MUL) |=> (cnt == MUL_M1)); // R7

    AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (rst)
        (!busy && !load) |=> (cnt == '0)); // R7

endmodule

// File: rtl/dual_issue_pair.sv
module dual_issue_pair
    import pair_pkg::*;
#(
    parameter int CLD_CYC = 2,
    parameter int MUL_CYC = 11,
    parameter int STR_CYC = 12,
    localparam int MAX_A  = (MUL_CYC > CLD_CYC) ? MUL_CYC : CLD_CYC,
    localparam int MAX_CYC = (STR_CYC > MAX_A) ? STR_CYC : MAX_A,
    localparam int CW     = (MAX_CYC > 2) ? $clog2(MAX_CYC) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          a_valid,
    input  logic [1:0]    a_cls,
    input  logic          a_prefix,
    input  logic          a_immdisp,
    input  logic [1:0]    a_stk,
    input  logic [1:0]    a_long,
    input  logic          b_valid,
    input  logic [1:0]    b_cls,
    input  logic          b_prefix,
    input  logic          b_immdisp,
    input  logic [1:0]    b_stk,
    input  logic [1:0]    b_long,
    input  logic          dep_hazard,
    output logic          issue_u,
    output logic          issue_v,
    output logic [CW-1:0] stall_cnt
);

    slot_desc_t desc [2];
    slot_info_t info [2];
    logic       busy;

    always_comb begin
        desc[0].valid   = a_valid;
        desc[0].cls     = pair_cls_e'(a_cls);
        desc[0].prefix  = a_prefix;
        desc[0].immdisp = a_immdisp;
        desc[0].stk     = stack_kind_e'(a_stk);
        desc[0].lng     = long_kind_e'(a_long);
        desc[1].valid   = b_valid;
        desc[1].cls     = pair_cls_e'(b_cls);
        desc[1].prefix  = b_prefix;
        desc[1].immdisp = b_immdisp;
        desc[1].stk     = stack_kind_e'(b_stk);
        desc[1].lng     = long_kind_e'(b_long);
    end

    generate
        for (genvar g = 0; g < 2; g++) begin : g_slot
            pair_classify #(.IS_OLDER(g == 0)) u_cls (
                .desc (desc[g]),
                .info (info[g])
            );
        end
    endgenerate

    pair_decide u_decide (
        .clk     (clk),
        .rst     (rst),
        .older   (info[0]),
        .younger (info[1]),
        .hazard  (dep_hazard),
        .busy    (busy),
        .issue_u (issue_u),
        .issue_v (issue_v)
    );

    pair_busy #(
        .CLD_CYC (CLD_CYC),
        .MUL_CYC (MUL_CYC),
        .STR_CYC (STR_CYC),
        .CW      (CW)
    ) u_busy (
        .clk  (clk),
        .rst  (rst),
        .load (issue_u),
        .lng  (desc[0].lng),
        .cnt  (stall_cnt),
        .busy (busy)
    );

    AST_IMMDISP_NO_PAIR: assert property (@(posedge clk) disable iff (rst)
        (a_immdisp || b_immdisp) |-> !issue_v); // R1

    AST_PREFIX_DEMOTE: assert property (@(posedge clk) disable iff (rst)
        (b_prefix && b_cls == 2'b00) |-> !issue_v); // R2

    AST_STALL_GATES: assert property (@(posedge clk) disable iff (rst)
        (stall_cnt != '0) |-> (!issue_u && !issue_v)); // R7

    AST_HAZARD_STACK: assert property (@(posedge clk) disable iff (rst)
        (issue_v && dep_hazard) |-> (a_stk == 2'b01)); // R8

    AST_LONG_NO_PAIR: assert property (@(posedge clk) disable iff (rst)
        ((a_long != 2'b00) || (b_long != 2'b00)) |-> !issue_v); // R7

    AST_RESET_CLEAR: assert property (@(posedge clk)
        $past(rst) |-> (stall_cnt == '0)); // R9

endmodule

// File: tb/dual_issue_pair_tb_top.sv
module dual_issue_pair_tb_top;

    localparam int CLK_NS   = 8;
    localparam int CW       = 4;
    localparam int WD_CYC   = 100000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          a_valid = 0, a_prefix = 0, a_immdisp = 0;
    logic [1:0]    a_cls = 0, a_stk = 0, a_long = 0;
    logic          b_valid = 0, b_prefix = 0, b_immdisp = 0;
    logic [1:0]    b_cls = 0, b_stk = 0, b_long = 0;
    logic          dep_hazard = 0;
    logic          issue_u, issue_v;
    logic [CW-1:0] stall_cnt;

    int  n_cmp  = 0;
    int  n_bad  = 0;
    int  m_busy = 0;
    bit  done   = 0;

    always #(CLK_NS/2) clk = ~clk;

    dual_issue_pair dut_i (
        .clk(clk), .rst(rst),
        .a_valid(a_valid), .a_cls(a_cls), .a_prefix(a_prefix),
        .a_immdisp(a_immdisp), .a_stk(a_stk), .a_long(a_long),
        .b_valid(b_valid), .b_cls(b_cls), .b_prefix(b_prefix),
        .b_immdisp(b_immdisp), .b_stk(b_stk), .b_long(b_long),
        .dep_hazard(dep_hazard),
        .issue_u(issue_u), .issue_v(issue_v), .stall_cnt(stall_cnt)
    );

    function automatic int model_class(int cls, bit pre, bit imm, int lng);
        if (imm) return 3;
        if (lng != 0) return 3;
        if (cls == 0 && pre) return 1;
        return cls;
    endfunction

    function automatic int model_cycles(int lng);
        case (lng)
            1: return 2;
            2: return 11;
            3: return 12;
            default: return 1;
        endcase
    endfunction

    task automatic check(string tag, string what, int got, int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    task automatic step(string tag, bit r,
                        bit av, int ac, bit ap, bit ai, int as_, int al,
                        bit bv, int bc, bit bp, bit bi, int bs, int bl,
                        bit hz);
        int ca, cb;
        bit eu, ev, stack_ok;
        @(negedge clk);
        rst = r;
        a_valid = av; a_cls = ac[1:0]; a_prefix = ap; a_immdisp = ai;
        a_stk = as_[1:0]; a_long = al[1:0];
        b_valid = bv; b_cls = bc[1:0]; b_prefix = bp; b_immdisp = bi;
        b_stk = bs[1:0]; b_long = bl[1:0];
        dep_hazard = hz;
        #1;
        ca = model_class(ac, ap, ai, al);
        cb = model_class(bc, bp, bi, bl);
        stack_ok = (as_ == 1) && (bs == 1 || bs == 2);
        eu = av && (m_busy == 0);
        ev = eu && bv && (ca == 0 || ca == 1) && (cb == 0 || cb == 2)
             && (!hz || stack_ok);
        check(tag, "stall_cnt", int'(stall_cnt), m_busy);
        check(tag, "issue_u", int'(issue_u), int'(eu));
        check(tag, "issue_v", int'(issue_v), int'(ev));
        @(posedge clk);
        if (r) m_busy = 0;
        else if (m_busy > 0) m_busy--;
        else if (eu) m_busy = model_cycles(al) - 1;
    endtask

    task automatic pair_plain(string tag, int n);
        for (int i = 0; i < n; i++)
            step(tag, 0, 1, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic finish_run();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_NS * WD_CYC);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got hung run expected completion");
            finish_run();
        end
    end

    initial begin
        // R9: reset state
        step("R9", 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        step("R9", 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        // R3: pairable combinations
        step("R3", 0, 1, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0);
        step("R3", 0, 1, 0, 0, 0, 0, 0, 1, 2, 0, 0, 0, 0, 0);
        step("R3", 0, 1, 1, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0);
        step("R3", 0, 1, 1, 0, 0, 0, 0, 1, 2, 0, 0, 0, 0, 0);
        // R4: older V-only or not pairable
        step("R4", 0, 1, 2, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0);
        step("R4", 0, 1, 3, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0);
        // R5: younger U-only or not pairable
        step("R5", 0, 1, 0, 0, 0, 0, 0, 1, 1, 0, 0, 0, 0, 0);
        step("R5", 0, 1, 0, 0, 0, 0, 0, 1, 3, 0, 0, 0, 0, 0);
        // R1: immediate plus displacement
        step("R1", 0, 1, 0, 0, 1, 0, 0, 1, 0, 0, 0, 0, 0, 0);
        step("R1", 0, 1, 0, 0, 0, 0, 0, 1, 2, 0, 1, 0, 0, 0);
        // R2: prefix demotion
        step("R2", 0, 1, 0, 1, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0);
        step("R2", 0, 1, 0, 0, 0, 0, 0, 1, 0, 1, 0, 0, 0, 0);
        step("R2", 0, 1, 0, 0, 0, 0, 0, 1, 2, 1, 0, 0, 0, 0);
        step("R2", 0, 1, 2, 1, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0);
        // R6: slot validity
        step("R6", 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0);
        step("R6", 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        // R8: hazard and stack chain exemption
        step("R8", 0, 1, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 1);
        step("R8", 0, 1, 0, 0, 0, 1, 0, 1, 0, 0, 0, 1, 0, 1);
        step("R8", 0, 1, 0, 0, 0, 1, 0, 1, 2, 0, 0, 2, 0, 1);
        step("R8", 0, 1, 0, 0, 0, 1, 0, 1, 0, 0, 0, 0, 0, 1);
        step("R8", 0, 1, 2, 0, 0, 2, 0, 1, 0, 0, 0, 1, 0, 1);
        // R7: multiply stall with a pairable pair waiting
        step("R7", 0, 1, 0, 0, 0, 0, 2, 1, 0, 0, 0, 0, 0, 0);
        pair_plain("R7", 12);
        // R7: string and flag-clear stalls
        step("R7", 0, 1, 0, 0, 0, 0, 3, 1, 0, 0, 0, 0, 0, 0);
        pair_plain("R7", 13);
        step("R7", 0, 1, 0, 0, 0, 0, 1, 1, 0, 0, 0, 0, 0, 0);
        pair_plain("R7", 3);
        // R7: long op in younger slot does not pair
        step("R7", 0, 1, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 2, 0);
        // R9: reset in the middle of a stall
        step("R9", 0, 1, 0, 0, 0, 0, 2, 0, 0, 0, 0, 0, 0, 0);
        pair_plain("R9", 3);
        step("R9", 1, 1, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0);
        pair_plain("R9", 2);
        // mixed stimulus: R3 R4 R5 R7 R8
        for (int i = 0; i < 600; i++) begin
            step("R3 R4 R5 R7 R8", 0,
                 ($urandom % 8) != 0, $urandom % 4, ($urandom % 4) == 0,
                 ($urandom % 8) == 0, $urandom % 3,
                 (($urandom % 10) == 0) ? ($urandom % 4) : 0,
                 ($urandom % 8) != 0, $urandom % 4, ($urandom % 4) == 0,
                 ($urandom % 8) == 0, $urandom % 3,
                 (($urandom % 10) == 0) ? ($urandom % 4) : 0,
                 ($urandom % 3) == 0);
        end
        finish_run();
    end

endmodule